// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller that sits beside a successive-approximation converter. It leaves reset in a calibration phase of fixed length and holds a calibration flag high for the whole of it. After that it waits for a one-cycle start request. Each conversion runs through five phases in turn: a one-cycle synchronising read, a programmable sample window, a bit-trial phase with one cycle per result bit, a two-cycle post-calibration slot and a one-cycle synchronising write.

During the bit-trial phase the block presents a trial code to the capacitor array and reads back a one-bit comparator decision. It keeps each trial bit for which the comparator reports 1, working from the MSB down. Status outputs show when the converter is sampling, when it is busy and when a fresh result is waiting.

Start requests are ignored while calibration or a conversion is running. A separate power-down input gates off the comparator path without disturbing the sequence.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset is released, `calibrate_o` stays high for exactly 3840 clock cycles, and `busy_o`, `sample_o` and `datavalid_o` stay low during that time. While reset is held, `calibrate_o` is 1 and `result_o` is 0.
- R2: A start pulse that is seen in the idle state is accepted on that clock edge. The value on `chan_i` is captured onto `chan_o`, which holds it until the next accepted start.
- R3: On the edge that accepts a start, `sample_o` and `busy_o` both rise and `datavalid_o` falls.
- R4: `sample_o` stays high for `stc_i + 3` cycles: one sync-read cycle plus a sample window of `stc_i + 2` cycles. `busy_o` is still high when `sample_o` falls.
- R5: `busy_o` stays high for `stc_i + N + 6` cycles, where N is the resolution. On the edge where `busy_o` falls, `datavalid_o` rises and `result_o` carries the new value.
- R6: Bit trials run MSB first. The trial code appears on `dac_code_o`, and a bit is kept when `cmp_i` is 1. With a comparator that returns (trial code ≤ V), the result equals V with its unresolved low bits cleared.
- R7: `mode_i[1:0]` selects the resolution: 00 gives 10 bits, 10 gives 8 bits, and 01 or 11 gives 12 bits. Unused low bits of `result_o` read 0.
- R8: `datavalid_o` and `result_o` hold their values, however long the block stays idle, until the next accepted start.
- R9: `postcal_o` is high for the 2 cycles just before the sync-write cycle. During those cycles `postcal_tgt_o` names the target: 0 for the offset, k for array bit k. The target starts at 0 after reset and advances by one per conversion, wrapping from 12 back to 0.
- R10: `cmp_en_o` is high during calibration and during conversions. In idle it equals `mode_i[2]` as captured at the last accepted start; before any conversion it is 1.
- R11: While `pwrdn_i` is 1, `cmp_en_o` is 0 and the comparator reads as 0, so the result bits are all 0. Phase timing and the post-calibration rotation are unaffected.
- R12: A start pulse during calibration or while `busy_o` is high is ignored. Calibration length, conversion length and `chan_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 5 | Channel number to sample |
| stc_i | input | 8 | Sample-time control |
| mode_i | input | 3 | [1:0] resolution select, [2] keep comparator on when idle |
| pwrdn_i | input | 1 | Comparator power-down |
| cmp_i | input | 1 | Comparator decision (1 = keep trial bit) |
| calibrate_o | output | 1 | Power-up calibration in progress |
| sample_o | output | 1 | Sampling in progress |
| busy_o | output | 1 | Conversion in progress |
| datavalid_o | output | 1 | Result ready |
| result_o | output | 12 | Conversion result, MSB aligned |
| chan_o | output | 5 | Channel of the current or last conversion |
| dac_code_o | output | 12 | Trial code driven to the capacitor array |
| postcal_o | output | 1 | Post-calibration slot active |
| postcal_tgt_o | output | 4 | Post-calibration target (0 = offset, k = bit k) |
| cmp_en_o | output | 1 | Comparator power enable |

## Verification
The bench targets the extremes of the sample window, `stc_i` of 0 and of 255. An off-by-one in the phase counter would stretch or shorten `sample_o` and `busy_o` by a cycle. It drives analog values at 0, full scale and alternating bit patterns in every resolution mode, so a mis-ordered trial or a wrong mask would leave stray low bits in `result_o`. It injects start pulses inside calibration and in the middle of a conversion, which a block that accepted them would show as a changed `chan_o` or a changed busy length. It also runs conversions with the comparator powered down: a block that reset on power-down would break the post-calibration rotation, and one that still used the comparator would return a non-zero result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_CAL,
        PH_IDLE,
        PH_SYNC_RD,
        PH_SAMPLE,
        PH_DIST,
        PH_POSTCAL,
        PH_SYNC_WR
    } phase_e;

    // Resolution chosen by the two low mode bits, relative to the full width.
    function automatic int unsigned res_bits(input logic [1:0] sel, input int unsigned full);
        case (sel)
            2'b00:   return full - 2;
            2'b10:   return full - 4;
            default: return full;
        endcase
    endfunction

endpackage

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
    import sar_seq_pkg::*;
#(
    parameter int unsigned CAL_CYCLES  = 3840,
    parameter int unsigned STC_W       = 8,
    parameter int unsigned CH_W        = 5,
    parameter int unsigned RES_W       = 12,
    parameter int unsigned MODE_W      = 3,
    parameter int unsigned POSTCAL_CYC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [CH_W-1:0]            chan_i,
    input  logic [STC_W-1:0]           stc_i,
    input  logic [MODE_W-1:0]          mode_i,
    output phase_e                     phase_o,
    output logic                       accept_o,
    output logic                       done_o,
    output logic [CH_W-1:0]            chan_o,
    output logic [$clog2(RES_W+1)-1:0] nbits_o,
    output logic                       keep_o,
    output logic                       dv_o
);
    localparam int unsigned SAMP_MAX = (1 << STC_W) + 2;
    localparam int unsigned CNT_MAX  = (CAL_CYCLES > SAMP_MAX) ? CAL_CYCLES : SAMP_MAX;
    localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
    localparam int unsigned NB_W     = $clog2(RES_W + 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [CH_W-1:0]    chan;
        logic [STC_W-1:0]   stc;
        logic [NB_W-1:0]    nbits;
        logic               keep;
        logic               dv;
    } ctl_t;

    ctl_t st_q, st_d;
    logic accept_d, done_d;

    always_comb begin
        st_d     = st_q;
        accept_d = 1'b0;
        done_d   = 1'b0;
        case (st_q.phase)
            PH_CAL: begin
                if (st_q.cnt == CNT_W'(CAL_CYCLES - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_IDLE: begin
                if (start_i) begin
                    accept_d    = 1'b1;
                    st_d.phase  = PH_SYNC_RD;
                    st_d.cnt    = '0;
                    st_d.chan   = chan_i;
                    st_d.stc    = stc_i;
                    st_d.nbits  = NB_W'(res_bits(mode_i[1:0], RES_W));
                    st_d.keep   = mode_i[2];
                    st_d.dv     = 1'b0;
                end
            end
            PH_SYNC_RD: begin
                st_d.phase = PH_SAMPLE;
                st_d.cnt   = '0;
            end
            PH_SAMPLE: begin
                if (st_q.cnt == CNT_W'(st_q.stc) + CNT_W'(1)) begin
                    st_d.phase = PH_DIST;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_DIST: begin
                if (st_q.cnt == CNT_W'(st_q.nbits) - CNT_W'(1)) begin
                    st_d.phase = PH_POSTCAL;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_POSTCAL: begin
                if (st_q.cnt == CNT_W'(POSTCAL_CYC - 1)) begin
                    st_d.phase = PH_SYNC_WR;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_SYNC_WR: begin
                done_d     = 1'b1;
                st_d.dv    = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_CAL;
            st_q.cnt   <= '0;
            st_q.chan  <= '0;
            st_q.stc   <= '0;
            st_q.nbits <= NB_W'(RES_W);
            st_q.keep  <= 1'b1;
            st_q.dv    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign accept_o = accept_d;
    assign done_o   = done_d;
    assign chan_o   = st_q.chan;
    assign nbits_o  = st_q.nbits;
    assign keep_o   = st_q.keep;
    assign dv_o     = st_q.dv;

    // R1
    cal_exit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.phase) == PH_CAL && st_q.phase != PH_CAL)
            |-> $past(st_q.cnt) == CNT_W'(CAL_CYCLES - 1));

    // R12
    start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st_q.phase != PH_IDLE) |=> $stable(st_q.chan));

    // R12
    cal_never_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CAL) |=> (st_q.phase == PH_CAL || st_q.phase == PH_IDLE));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             cmp_i,
    input  logic             load_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic [RES_W-1:0] result_o
);
    localparam int unsigned PTR_W = (RES_W > 1) ? $clog2(RES_W) : 1;

    typedef struct packed {
        logic [RES_W-1:0] sar;
        logic [PTR_W-1:0] ptr;
        logic [RES_W-1:0] res;
    } eng_t;

    eng_t st_q, st_d;
    logic [RES_W-1:0] trial;

    always_comb begin
        st_d  = st_q;
        trial = st_q.sar | (RES_W'(1) << st_q.ptr);
        if (clr_i) begin
            st_d.sar = '0;
            st_d.ptr = PTR_W'(RES_W - 1);
        end else if (step_i) begin
            if (cmp_i) begin
                st_d.sar = trial;
            end
            if (st_q.ptr != '0) begin
                st_d.ptr = st_q.ptr - PTR_W'(1);
            end
        end
        if (load_i) begin
            st_d.res = st_q.sar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sar <= '0;
            st_q.ptr <= PTR_W'(RES_W - 1);
            st_q.res <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code_o = step_i ? trial : st_q.sar;
    assign result_o   = st_q.res;

    // R6
    reject_keeps_sar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cmp_i && !clr_i) |=> $stable(st_q.sar));

    // R6
    one_bit_per_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i) |=> ($countones(st_q.sar ^ $past(st_q.sar)) <= 1));
endmodule

// File: rtl/sar_postcal_rot.sv
module sar_postcal_rot #(
    parameter int unsigned RES_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    output logic [$clog2(RES_W+1)-1:0] tgt_o
);
    localparam int unsigned TGT_W = $clog2(RES_W + 1);

    typedef struct packed {
        logic [TGT_W-1:0] tgt;
    } rot_t;

    rot_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.tgt = (st_q.tgt == TGT_W'(RES_W)) ? '0 : st_q.tgt + TGT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tgt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt_o = st_q.tgt;

    // R9
    tgt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tgt <= TGT_W'(RES_W));

    // R9
    tgt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(st_q.tgt));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned CAL_CYCLES  = 3840,
    parameter int unsigned STC_W       = 8,
    parameter int unsigned CH_W        = 5,
    parameter int unsigned RES_W       = 12,
    parameter int unsigned MODE_W      = 3,
    parameter int unsigned POSTCAL_CYC = 2,
    parameter int unsigned TGT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [STC_W-1:0] stc_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic             pwrdn_i,
    input  logic             cmp_i,
    output logic             calibrate_o,
    output logic             sample_o,
    output logic             busy_o,
    output logic             datavalid_o,
    output logic [RES_W-1:0] result_o,
    output logic [CH_W-1:0]  chan_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic             postcal_o,
    output logic [TGT_W-1:0] postcal_tgt_o,
    output logic             cmp_en_o
);
    localparam int unsigned NB_W = $clog2(RES_W + 1);

    phase_e          phase;
    logic            accept, done, keep, cmp_eff;
    logic [NB_W-1:0] nbits;
    logic [NB_W-1:0] tgt;

    sar_phase_ctl #(
        .CAL_CYCLES (CAL_CYCLES),
        .STC_W      (STC_W),
        .CH_W       (CH_W),
        .RES_W      (RES_W),
        .MODE_W     (MODE_W),
        .POSTCAL_CYC(POSTCAL_CYC)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .chan_i  (chan_i),
        .stc_i   (stc_i),
        .mode_i  (mode_i),
        .phase_o (phase),
        .accept_o(accept),
        .done_o  (done),
        .chan_o  (chan_o),
        .nbits_o (nbits),
        .keep_o  (keep),
        .dv_o    (datavalid_o)
    );

    assign cmp_eff = cmp_i & ~pwrdn_i;

    sar_bit_engine #(.RES_W(RES_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .step_i    (phase == PH_DIST),
        .cmp_i     (cmp_eff),
        .load_i    (done),
        .dac_code_o(dac_code_o),
        .result_o  (result_o)
    );

    sar_postcal_rot #(.RES_W(RES_W)) u_rot (
        .clk  (clk),
        .rst_n(rst_n),
        .adv_i(done),
        .tgt_o(tgt)
    );

    assign calibrate_o   = (phase == PH_CAL);
    assign sample_o      = (phase == PH_SYNC_RD) || (phase == PH_SAMPLE);
    assign busy_o        = (phase != PH_CAL) && (phase != PH_IDLE);
    assign postcal_o     = (phase == PH_POSTCAL);
    assign postcal_tgt_o = TGT_W'(tgt);
    assign cmp_en_o      = !pwrdn_i && ((phase != PH_IDLE) || keep);

    // R3
    start_raises_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !calibrate_o) |=> (sample_o && busy_o && !datavalid_o));

    // R4
    sample_ends_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> busy_o);

    // R5
    busy_fall_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> datavalid_o);

    // R7
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (datavalid_o && nbits < NB_W'(RES_W))
            |-> ((result_o & ((RES_W'(1) << (NB_W'(RES_W) - nbits)) - RES_W'(1))) == '0));

    // R8
    result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (datavalid_o && !(start_i && !busy_o)) |=> ($stable(result_o) && datavalid_o));

    // R11
    pwrdn_gates_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_i |-> !cmp_en_o);

    // R1
    cal_excludes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calibrate_o |-> (!busy_o && !sample_o && !datavalid_o));
endmodule

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  chan_i = '0;
    logic [7:0]  stc_i = '0;
    logic [2:0]  mode_i = '0;
    logic        pwrdn_i = 1'b0;
    logic        cmp_i;
    logic        calibrate_o, sample_o, busy_o, datavalid_o, postcal_o, cmp_en_o;
    logic [11:0] result_o, dac_code_o;
    logic [4:0]  chan_o;
    logic [3:0]  postcal_tgt_o;
    logic [11:0] vin_r = '0;

    int nchk = 0;
    int nerr = 0;
    int exp_tgt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // Analog model: comparator says keep when the trial code does not exceed the input.
    assign cmp_i = (dac_code_o <= vin_r);

    sar_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .stc_i(stc_i),
        .mode_i(mode_i), .pwrdn_i(pwrdn_i), .cmp_i(cmp_i), .calibrate_o(calibrate_o),
        .sample_o(sample_o), .busy_o(busy_o), .datavalid_o(datavalid_o),
        .result_o(result_o), .chan_o(chan_o), .dac_code_o(dac_code_o),
        .postcal_o(postcal_o), .postcal_tgt_o(postcal_tgt_o), .cmp_en_o(cmp_en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_nbits(input logic [1:0] sel);
        if (sel == 2'b00) return 10;
        if (sel == 2'b10) return 8;
        return 12;
    endfunction

    function automatic int exp_result(input int v, input logic [1:0] sel, input bit pd);
        int n = exp_nbits(sel);
        int mask = ((1 << n) - 1) << (12 - n);
        return pd ? 0 : (v & mask);
    endfunction

    task automatic conv(input int v, input int stc, input logic [2:0] mode,
                        input int ch, input bit pd, input bit inject);
        int nb = 0, ns = 0, npc = 0, tgt_seen = -1, guard = 0;
        @(negedge clk);
        vin_r   = 12'(v);
        stc_i   = 8'(stc);
        mode_i  = mode;
        chan_i  = 5'(ch);
        pwrdn_i = pd;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R3: both status flags rise on the accepting edge
        chk(sample_o && busy_o && !datavalid_o, "R3 sample/busy rise", {sample_o, busy_o, datavalid_o}, 3'b110);
        // R2: channel captured
        chk(chan_o == 5'(ch), "R2 channel", chan_o, ch);
        while (busy_o && guard < 2000) begin
            guard++;
            nb++;
            if (sample_o) ns++;
            if (postcal_o) begin
                npc++;
                tgt_seen = postcal_tgt_o;
                // R9: post-cal sits right before sync write
                if (npc == 1)
                    chk(nb == stc + 3 + exp_nbits(mode[1:0]) + 1, "R9 postcal position", nb,
                        stc + 3 + exp_nbits(mode[1:0]) + 1);
            end
            // R10/R11: comparator enable during conversion
            chk(cmp_en_o == !pd, "R10 R11 cmp_en busy", cmp_en_o, !pd);
            if (inject && nb == 3) begin
                start_i = 1'b1;       // R12: must be ignored
                chan_i  = ~5'(ch);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(ns == stc + 3, "R4 sample length", ns, stc + 3);
        chk(nb == stc + exp_nbits(mode[1:0]) + 6, "R5 busy length", nb, stc + exp_nbits(mode[1:0]) + 6);
        chk(datavalid_o, "R5 datavalid rises", datavalid_o, 1);
        chk(result_o == 12'(exp_result(v, mode[1:0], pd)), "R6 R7 R11 result", result_o,
            exp_result(v, mode[1:0], pd));
        chk(npc == 2, "R9 postcal cycles", npc, 2);
        chk(tgt_seen == exp_tgt, "R9 postcal target", tgt_seen, exp_tgt);
        exp_tgt = (exp_tgt == 12) ? 0 : exp_tgt + 1;
        chk(chan_o == 5'(ch), "R12 channel after ignored start", chan_o, ch);
        chk(cmp_en_o == (!pd && mode[2]), "R10 idle cmp_en", cmp_en_o, !pd && mode[2]);
    endtask

    task automatic hold_check(input int cycles);
        logic [11:0] r = result_o;
        repeat (cycles) @(negedge clk);
        chk(datavalid_o && result_o == r, "R8 result held", result_o, r);
    endtask

    initial begin
        int n;
        bit saw_busy;
        void'($urandom(32'h1357_2468));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(calibrate_o && !busy_o && !sample_o && !datavalid_o, "R1 reset flags",
            {calibrate_o, busy_o, sample_o, datavalid_o}, 4'b1000);
        chk(result_o == 0, "R1 reset result", result_o, 0);
        chk(cmp_en_o == 1, "R10 reset cmp_en", cmp_en_o, 1);
        rst_n = 1'b1;
        n = 0;
        saw_busy = 0;
        while (calibrate_o && n < 5000) begin
            start_i = (n == 100);   // R12: start during calibration
            chan_i  = 5'd17;
            if (busy_o || sample_o || datavalid_o) saw_busy = 1;
            n++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(n == 3840, "R1 calibration length", n, 3840);
        chk(!saw_busy, "R1 R12 no activity in calibration", saw_busy, 0);
        chk(!busy_o && chan_o == 0, "R12 cal start ignored", chan_o, 0);

        // Directed corners
        conv(12'hFFF, 0,   3'b101, 3,  0, 0);
        hold_check(20);
        conv(0,       255, 3'b001, 31, 0, 0);
        conv(12'hAAA, 1,   3'b000, 5,  0, 0);
        conv(12'h555, 2,   3'b110, 9,  0, 1);
        conv(12'hFFF, 4,   3'b111, 12, 1, 0);
        conv(12'h7FF, 0,   3'b011, 1,  0, 1);
        conv(12'h800, 3,   3'b100, 2,  1, 0);
        hold_check(7);

        // Random mix
        for (int i = 0; i < 30; i++) begin
            int v    = $urandom_range(0, 4095);
            int stc  = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 15);
            logic [2:0] m = 3'($urandom_range(0, 7));
            int ch   = $urandom_range(0, 31);
            bit pd   = ($urandom_range(0, 5) == 0);
            bit inj  = ($urandom_range(0, 3) == 0);
            conv(v, stc, m, ch, pd, inj);
            if ($urandom_range(0, 3) == 0) hold_check($urandom_range(1, 10));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule